// File: doc/BRIEF.md
# Programmable-Latency Synchronous Burst Read Port

This block is the device side of a synchronous burst read port on a 16-bit memory. The host asserts an address-valid strobe together with a start address. The block then waits an initial latency that software can program. After that wait it presents one data word on every rising clock edge. The words come from a behavioural array, and the burst walks through an aligned group of eight words, wrapping back to the start of the group.

A ready handshake rises one clock before the first valid word and stays high while the burst runs. Because of this, the host can watch ready instead of counting cycles itself. The output drivers are modelled as a data bus plus a drive-enable flag. The flag is active only while both chip enable and output enable are asserted; both are active low.

A three-bit latency register selects the number of initial cycles.

Top module: `brl_burst_read`

## Requirements
- R1: After reset the latency register holds 4, `rdy_o` is 0 and `dq_o` is 0.
- R2: A write with `cfg_we_i`=1 and `cfg_lat_i` in 3..7 loads the latency L. The new value governs every burst started on a later edge.
- R3: A write with `cfg_lat_i` of 0, 1 or 2 is ignored, and the previous latency stays in force.
- R4: Edge E0 is an edge where `avd_i`=1 and `ce_ni`=0. E0 latches `addr_i`, and `dq_o` is 0 after E0. The first word appears on `dq_o` after edge E(L-1), so the host samples it at E(L). `dq_o` stays 0 until then.
- R5: After each later edge, `dq_o` advances to the next word of the burst. The burst continues until a new strobe or until chip enable goes inactive.
- R6: Word j of a burst comes from address {A[15:3], (A[2:0]+j) mod 8}, where A is the latched address. The word after offset 7 is offset 0 of the same group.
- R7: `rdy_o` is 0 after E0. It rises after edge E(L-2), one clock before the first word, and stays 1 while the burst continues.
- R8: A strobe during the wait or the data phase aborts the running burst. It relatches the address and restarts the latency count with the current L.
- R9: Any edge with `ce_ni`=1 ends the burst, with `rdy_o`=0 and `dq_o`=0 after that edge. A strobe seen while `ce_ni`=1 starts nothing.
- R10: `dq_oe_o` is 1 exactly when `ce_ni`=0 and `oe_ni`=0. `oe_ni` has no effect on burst sequencing.
- R11: The array word at address a is the low 16 bits of (a * 0x9E37), XOR 0x5A5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| avd_i | input | 1 | Address-valid strobe, active high |
| addr_i | input | 16 | Burst start address |
| cfg_we_i | input | 1 | Latency register write strobe |
| cfg_lat_i | input | 3 | Latency value to write |
| rdy_o | output | 1 | Ready handshake |
| dq_oe_o | output | 1 | Data drive enable; 0 means bus in high impedance |
| dq_o | output | 16 | Burst data word |

## Verification
The assertions take for granted that a latency write never falls on the same edge as a burst start. They also assume the host holds `ce_ni` at 0 for the whole of a burst it wants to observe. The stimulus keeps both rules: configuration writes are issued only in cycles with the strobe low, and chip enable is released only in the dedicated abort sequence. Beyond those rules, the start addresses, burst lengths, latency writes (legal and illegal) and output-enable toggling are drawn at random, with a fixed seed.

// File: rtl/brl_pkg.sv
package brl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } brl_state_e;
endpackage

// File: rtl/brl_cfg_reg.sv
module brl_cfg_reg #(
  parameter int LAT_W   = 3,
  parameter int LAT_MIN = 3,
  parameter int LAT_MAX = 7,
  parameter int LAT_RST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic [LAT_W-1:0] lat_o
);
  localparam logic [LAT_W-1:0] LoLim = LAT_W'(LAT_MIN);
  localparam logic [LAT_W-1:0] HiLim = LAT_W'(LAT_MAX);

  logic legal;
  assign legal = (lat_i >= LoLim) && (lat_i <= HiLim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             lat_o <= LAT_W'(LAT_RST);
    else if (we_i && legal)  lat_o <= lat_i;
  end
endmodule

// File: rtl/brl_seq.sv
module brl_seq
  import brl_pkg::*;
#(
  parameter int LAT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             fetch_o,
  output logic             in_burst_o,
  output logic             rdy_o
);
  brl_state_e       state_q;
  logic [LAT_W-1:0] wcnt_q;

  // wait count starts at L-2 so ready rises one edge before first fetch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      rdy_o   <= 1'b0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      rdy_o   <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_WAIT;
      wcnt_q  <= lat_i - LAT_W'(2);
      rdy_o   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (wcnt_q == '0) begin
            state_q <= ST_BURST;
          end else begin
            wcnt_q <= wcnt_q - LAT_W'(1);
            if (wcnt_q == LAT_W'(1)) rdy_o <= 1'b1;
          end
        end
        ST_BURST: state_q <= ST_BURST;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_burst_o = (state_q == ST_BURST);
  assign fetch_o    = !abort_i && !start_i &&
                      (in_burst_o || (state_q == ST_WAIT && wcnt_q == '0));
endmodule

// File: rtl/brl_addr_gen.sv
module brl_addr_gen #(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] word_addr_o
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] offs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (start_i) begin
      base_q <= addr_i;
      beat_q <= '0;
    end else if (fetch_i) begin
      beat_q <= beat_q + BURST_W'(1);
    end
  end

  // modulo add keeps the burst inside its aligned group
  assign offs        = base_q[BURST_W-1:0] + beat_q;
  assign word_addr_o = {base_q[ADDR_W-1:BURST_W], offs};
endmodule

// File: rtl/brl_array.sv
module brl_array #(
  parameter int                ADDR_W = 16,
  parameter int                DATA_W = 16,
  parameter logic [DATA_W-1:0] MULT   = 16'h9E37,
  parameter logic [DATA_W-1:0] SALT   = 16'h5A5A
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int PW = ADDR_W + DATA_W;
  logic [PW-1:0] prod;

  assign prod   = PW'(addr_i) * PW'(MULT);
  assign data_o = prod[DATA_W-1:0] ^ SALT;
endmodule

// File: rtl/brl_burst_read.sv
module brl_burst_read #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int LAT_W   = 3,
  parameter int LAT_MIN = 3,
  parameter int LAT_MAX = 7,
  parameter int LAT_RST = 4,
  parameter int BURST_N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              avd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cfg_we_i,
  input  logic [LAT_W-1:0]  cfg_lat_i,
  output logic              rdy_o,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] dq_o
);
  localparam int BURST_W = $clog2(BURST_N);

  logic              start;
  logic              fetch;
  logic              in_burst;
  logic [LAT_W-1:0]  lat_q;
  logic [ADDR_W-1:0] word_addr;
  logic [DATA_W-1:0] mem_word;
  logic [DATA_W-1:0] dq_q;

  assign start = avd_i && !ce_ni;

  brl_cfg_reg #(
    .LAT_W(LAT_W), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX), .LAT_RST(LAT_RST)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .lat_i(cfg_lat_i), .lat_o(lat_q)
  );

  brl_seq #(.LAT_W(LAT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .abort_i(ce_ni), .start_i(start), .lat_i(lat_q),
    .fetch_o(fetch), .in_burst_o(in_burst), .rdy_o(rdy_o)
  );

  brl_addr_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .fetch_i(fetch),
    .addr_i(addr_i), .word_addr_o(word_addr)
  );

  brl_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .addr_i(word_addr), .data_o(mem_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              dq_q <= '0;
    else if (ce_ni || start)  dq_q <= '0;
    else if (fetch)           dq_q <= mem_word;
  end

  assign dq_o    = dq_q;
  assign dq_oe_o = !ce_ni && !oe_ni;
endmodule

// File: rtl/brl_burst_read_chk.sv
module brl_burst_read_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int LAT_W   = 3,
  parameter int LAT_MIN = 3,
  parameter int LAT_MAX = 7,
  parameter int BURST_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              cfg_we_i,
  input logic [LAT_W-1:0]  cfg_lat_i,
  input logic              rdy_o,
  input logic [DATA_W-1:0] dq_o,
  input logic              start,
  input logic              fetch,
  input logic              in_burst,
  input logic [LAT_W-1:0]  lat_q,
  input logic [ADDR_W-1:0] word_addr
);
  logic bad_wr;
  assign bad_wr = cfg_we_i && ((cfg_lat_i < LAT_W'(LAT_MIN)) || (cfg_lat_i > LAT_W'(LAT_MAX)));

  AST_LAT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q >= LAT_W'(LAT_MIN)) && (lat_q <= LAT_W'(LAT_MAX)));  // R2

  AST_BAD_WRITE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> $stable(lat_q));  // R3

  AST_RDY_LOW_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !rdy_o);  // R7

  AST_RDY_BEFORE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch && !in_burst) |-> rdy_o);  // R7

  AST_WRAP_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_burst && $past(in_burst)) |-> $stable(word_addr[ADDR_W-1:BURST_W]));  // R6

  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (!rdy_o && dq_o == '0));  // R9
endmodule

bind brl_burst_read brl_burst_read_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT_W(LAT_W),
  .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX), .BURST_W(BURST_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .cfg_we_i(cfg_we_i),
  .cfg_lat_i(cfg_lat_i), .rdy_o(rdy_o), .dq_o(dq_o), .start(start),
  .fetch(fetch), .in_burst(in_burst), .lat_q(lat_q), .word_addr(word_addr)
);

// File: tb/tb_brl_burst_read.sv
`timescale 1ns/1ps
module tb_brl_burst_read;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1;
  logic        oe_ni = 1'b1;
  logic        avd_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_lat_i = '0;
  logic        rdy_o;
  logic        dq_oe_o;
  logic [15:0] dq_o;

  int errors = 0;
  int checks = 0;
  int lat_m  = 4;
  bit done   = 1'b0;
  int unsigned seed_v = 32'd1234;

  always #2 clk_i = ~clk_i;

  brl_burst_read dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .avd_i(avd_i),
    .addr_i(addr_i), .cfg_we_i(cfg_we_i), .cfg_lat_i(cfg_lat_i),
    .rdy_o(rdy_o), .dq_oe_o(dq_oe_o), .dq_o(dq_o)
  );

  function automatic logic [15:0] word_f(input logic [15:0] a);
    logic [31:0] p;
    p = {16'h0, a} * 32'h0000_9E37;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] wrap_f(input logic [15:0] a, input int j);
    logic [2:0] o;
    o = a[2:0] + 3'(j);
    return {a[15:3], o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [2:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_lat_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (v >= 3) lat_m = v;  // R2, R3 model
  endtask

  // issue strobe at E0, then check ncyc edges after it
  task automatic run_burst(input logic [15:0] a, input int ncyc);
    int L;
    logic [15:0] exp_d;
    bit exp_r;
    L = lat_m;
    @(negedge clk_i);
    avd_i = 1'b1; addr_i = a;
    @(posedge clk_i); #1;
    chk(rdy_o == 1'b0, "R7 rdy low after strobe", 16'(rdy_o), 16'd0);
    chk(dq_o == 16'h0, "R4 dq zero after strobe", dq_o, 16'h0);
    @(negedge clk_i);
    avd_i = 1'b0; addr_i = 16'($urandom);
    for (int k = 1; k <= ncyc; k++) begin
      @(posedge clk_i); #1;
      exp_r = (k >= L - 2);
      exp_d = (k >= L - 1) ? word_f(wrap_f(a, k - (L - 1))) : 16'h0;
      chk(rdy_o == exp_r, "R7 ready timing", 16'(rdy_o), 16'(exp_r));
      chk(dq_o == exp_d, (k == L - 1) ? "R4 first word edge" : "R5 R6 R11 burst word", dq_o, exp_d);
      oe_ni = 1'($urandom);
      #1;
      chk(dq_oe_o == !oe_ni, "R10 drive enable", 16'(dq_oe_o), 16'(!oe_ni));
    end
  endtask

  initial begin
    void'($urandom(seed_v));
    repeat (3) @(posedge clk_i);
    #1;
    chk(rdy_o == 1'b0, "R1 reset rdy", 16'(rdy_o), 16'd0);
    chk(dq_o == 16'h0, "R1 reset dq", dq_o, 16'h0);
    chk(dq_oe_o == 1'b0, "R10 ce high drive off", 16'(dq_oe_o), 16'd0);
    @(negedge clk_i);
    rst_ni = 1'b1; ce_ni = 1'b0;
    // R1 default latency 4
    run_burst(16'h1234, 14);

    // R2 sweep, directed wrap corners R6
    for (int L = 3; L <= 7; L++) begin
      cfg_write(3'(L));
      run_burst(16'h00F7, L + 9);
      run_burst(16'h8000, L + 9);
      run_burst(16'($urandom), L + 9);
    end

    // R3 illegal writes keep 5
    cfg_write(3'd5);
    cfg_write(3'd0);
    cfg_write(3'd1);
    cfg_write(3'd2);
    run_burst(16'hABCD, 14);

    // R8 restart in wait phase and in data phase
    run_burst(16'h0101, 2);
    run_burst(16'h2226, 8);
    run_burst(16'h3333, 12);

    // R9 abort and ignored strobe
    cfg_write(3'd4);
    run_burst(16'h4445, 6);
    @(negedge clk_i);
    ce_ni = 1'b1;
    @(posedge clk_i); #1;
    chk(rdy_o == 1'b0, "R9 abort rdy", 16'(rdy_o), 16'd0);
    chk(dq_o == 16'h0, "R9 abort dq", dq_o, 16'h0);
    chk(dq_oe_o == 1'b0, "R10 ce high drive off", 16'(dq_oe_o), 16'd0);
    @(negedge clk_i);
    avd_i = 1'b1; addr_i = 16'h5555;
    @(negedge clk_i);
    avd_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk_i); #1;
      chk(rdy_o == 1'b0, "R9 strobe ignored rdy", 16'(rdy_o), 16'd0);
      chk(dq_o == 16'h0, "R9 strobe ignored dq", dq_o, 16'h0);
    end
    @(negedge clk_i);
    ce_ni = 1'b0;
    run_burst(16'h6667, 12);

    // random mix
    for (int i = 0; i < 40; i++) begin
      if ($urandom % 3 == 0) cfg_write(3'($urandom));
      run_burst(16'($urandom), 1 + int'($urandom % 16));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule